// File: doc/BRIEF.md
# Recursive vertical-and-crosswise multiplier, 24 by 24 bits

This block multiplies two unsigned 24-bit operands and returns the full 48-bit product. Each operand is cut in half, and the four half-by-half products come from four 12x12 sub-multipliers. Each of those is built the same way from 6x6 squares, and each 6x6 square from 3x3 base squares. The 3x3 base square sums its column cross-products in the vertical-and-crosswise pattern.

At the top level the product is assembled in three parts. The low 12 bits come straight from the low-by-low sub-product. The two cross products and the overlapping halves of the outer sub-products pass through a carry-save stage. A 23-bit carry-select adder then resolves that stage into the middle 24 bits. The upper 12 bits come from the high-by-high sub-product plus the middle carry. The lower six of them use a 6-bit carry-select adder. The top six are picked by a 2:1 select: either the unchanged field, or that field plus one from a second 6-bit carry-select adder. The select is driven by the carry-out of the lower adder. Every XOR in the adders is made from an AND, a NAND and an OR.

A `PIPE` parameter adds one register stage between the sub-multipliers and the carry-save stage. The product leaves the block through an output register. A result is accepted every cycle.

Top module: `vm_mult24`

## Requirements
- R1: When `res_valid` is high, `res_prod` equals the unsigned product of the operand pair that was accepted with `in_valid` high the latency earlier, exact over all 48 bits.
- R2: `res_valid` equals `in_valid` delayed by the latency. The latency is 1 cycle when `PIPE` is 0 and 2 cycles when `PIPE` is 1. Back-to-back valid inputs give results on consecutive cycles.
- R3: Operands presented with `in_valid` low are ignored. While `res_valid` is low, `res_prod` keeps the last result.
- R4: A synchronous active-high `rst` clears `res_valid` and `res_prod` to zero on the clock edge where it is sampled. Results still in flight are discarded.
- R5: `res_prod[11:0]` equals the low 12 bits of `op_a[11:0]` times `op_b[11:0]`.
- R6: A middle carry that propagates through bits [41:36] increments bits [47:42] by one. For example, 0xFFFFFF times 0xFFFFFF gives 0xFFFFFE000001.
- R7: A zero operand gives a zero product, and an operand of 1 returns the other operand unchanged, including 0xFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands on this cycle are to be multiplied |
| op_a | input | 24 | Multiplicand, unsigned |
| op_b | input | 24 | Multiplier, unsigned |
| res_valid | output | 1 | `res_prod` holds a new result this cycle |
| res_prod | output | 48 | Registered unsigned product |

## Verification
The bound checker tracks its own delayed copy of the operands. On every cycle it checks the full product, the low 12-bit field, the valid timing, the hold while no result is due and the cleared state after reset. Some behaviours need chosen operand pairs to show up: the carry rippling into the top six bits, the ones-and-zeros corners and single-bit operands. Two cases come only from bench scenarios: a reset that drops results still in flight, and both latency variants running side by side.

// File: rtl/vm_pkg.sv
package vm_pkg;
  // Exclusive-or from three gates: (a OR b) AND (a NAND b)
  function automatic logic xr(input logic a, input logic b);
    logic g_or;
    logic g_nand;
    g_or   = a | b;
    g_nand = ~(a & b);
    return g_or & g_nand;
  endfunction

  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return xr(xr(a, b), c);
  endfunction

  function automatic logic fa_cry(input logic a, input logic b, input logic c);
    return (a & b) | (c & xr(a, b));
  endfunction
endpackage

// File: rtl/vm_csa.sv
module vm_csa #(
  parameter int W = 24
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] s,
  output logic [W-1:0] c
);
  import vm_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s[i] = fa_sum(x[i], y[i], z[i]);
    assign c[i] = fa_cry(x[i], y[i], z[i]);
  end
endmodule

// File: rtl/vm_csla.sv
module vm_csla #(
  parameter int W   = 23,
  parameter int BLK = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);
  import vm_pkg::*;

  localparam int NB = (W + BLK - 1) / BLK;

  logic [NB:0] bc;
  assign bc[0] = cin;
  assign cout  = bc[NB];

  for (genvar k = 0; k < NB; k++) begin : g_blk
    localparam int LSB = k * BLK;
    localparam int BW  = ((W - LSB) < BLK) ? (W - LSB) : BLK;

    logic [BW-1:0] s0, s1;
    logic [BW:0]   k0, k1;

    always_comb begin
      k0[0] = 1'b0;
      k1[0] = 1'b1;
      for (int i = 0; i < BW; i++) begin
        s0[i]   = fa_sum(a[LSB+i], b[LSB+i], k0[i]);
        k0[i+1] = fa_cry(a[LSB+i], b[LSB+i], k0[i]);
        s1[i]   = fa_sum(a[LSB+i], b[LSB+i], k1[i]);
        k1[i+1] = fa_cry(a[LSB+i], b[LSB+i], k1[i]);
      end
    end

    assign s[LSB+BW-1:LSB] = bc[k] ? s1 : s0;
    assign bc[k+1]         = bc[k] ? k1[BW] : k0[BW];
  end
endmodule

// File: rtl/vm_rec.sv
module vm_rec #(
  parameter int N = 12
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);
  if (N <= 3) begin : g_base
    // Column sums of the vertical-and-crosswise pattern
    logic [1:0]     col [0:2*N-2];
    logic [2*N-1:0] acc;
    always_comb begin
      for (int k = 0; k < 2*N-1; k++) col[k] = '0;
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          col[i+j] = col[i+j] + {1'b0, a[i] & b[j]};
      acc = '0;
      for (int k = 0; k < 2*N-1; k++)
        acc = acc + ({{(2*N-2){1'b0}}, col[k]} << k);
    end
    assign p = acc;
  end else begin : g_split
    localparam int H = N / 2;
    logic [N-1:0] ll, lh, hl, hh;

    vm_rec #(.N(H)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(ll));
    vm_rec #(.N(H)) u_lh (.a(a[H-1:0]), .b(b[N-1:H]), .p(lh));
    vm_rec #(.N(H)) u_hl (.a(a[N-1:H]), .b(b[H-1:0]), .p(hl));
    vm_rec #(.N(H)) u_hh (.a(a[N-1:H]), .b(b[N-1:H]), .p(hh));

    assign p = {{N{1'b0}}, ll}
             + ({{N{1'b0}}, lh} << H)
             + ({{N{1'b0}}, hl} << H)
             + ({hh, {N{1'b0}}});
  end
endmodule

// File: rtl/vm_mult24.sv
module vm_mult24 #(
  parameter int W    = 24,
  parameter int PIPE = 1,
  parameter int BLK  = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic           res_valid,
  output logic [2*W-1:0] res_prod
);
  import vm_pkg::*;

  localparam int H  = W / 2;
  localparam int LO = H / 2;
  localparam int HI = H - LO;

  // Quarter products
  logic [W-1:0] ll_c, lh_c, hl_c, hh_c;
  vm_rec #(.N(H)) u_ll (.a(op_a[H-1:0]), .b(op_b[H-1:0]), .p(ll_c));
  vm_rec #(.N(H)) u_lh (.a(op_a[H-1:0]), .b(op_b[W-1:H]), .p(lh_c));
  vm_rec #(.N(H)) u_hl (.a(op_a[W-1:H]), .b(op_b[H-1:0]), .p(hl_c));
  vm_rec #(.N(H)) u_hh (.a(op_a[W-1:H]), .b(op_b[W-1:H]), .p(hh_c));

  // Optional register stage in front of the carry-save stage
  logic [W-1:0] ll, lh, hl, hh;
  logic         v_s;
  if (PIPE != 0) begin : g_pipe
    always_ff @(posedge clk) begin
      if (rst) begin
        v_s <= 1'b0;
        ll  <= '0;
        lh  <= '0;
        hl  <= '0;
        hh  <= '0;
      end else begin
        v_s <= in_valid;
        if (in_valid) begin
          ll <= ll_c;
          lh <= lh_c;
          hl <= hl_c;
          hh <= hh_c;
        end
      end
    end
  end else begin : g_comb
    assign v_s = in_valid;
    assign ll  = ll_c;
    assign lh  = lh_c;
    assign hl  = hl_c;
    assign hh  = hh_c;
  end

  // Middle field: three operands -> sum and carry vectors
  logic [W-1:0] cs_s, cs_c;
  vm_csa #(.W(W)) u_csa (
    .x(lh), .y(hl), .z({hh[H-1:0], ll[W-1:H]}),
    .s(cs_s), .c(cs_c)
  );

  logic [W-2:0] mid_hi;
  logic         mid_co;
  vm_csla #(.W(W-1), .BLK(BLK)) u_mid (
    .a(cs_s[W-1:1]), .b(cs_c[W-2:0]), .cin(1'b0),
    .s(mid_hi), .cout(mid_co)
  );

  // Carry into the upper field is 0, 1 or 2
  logic [1:0] up_cy;
  assign up_cy = {mid_co & cs_c[W-1], xr(mid_co, cs_c[W-1])};

  logic [LO-1:0] up_lo;
  logic          lo_co;
  vm_csla #(.W(LO), .BLK(BLK)) u_up_lo (
    .a(hh[H+LO-1:H]), .b({{(LO-2){1'b0}}, up_cy}), .cin(1'b0),
    .s(up_lo), .cout(lo_co)
  );

  // Top field: add one through the carry input, then select
  logic [HI-1:0] hi_inc;
  logic          hi_co;
  vm_csla #(.W(HI), .BLK(BLK)) u_up_hi (
    .a(hh[W-1:H+LO]), .b({HI{1'b0}}), .cin(1'b1),
    .s(hi_inc), .cout(hi_co)
  );

  logic [HI-1:0] up_hi;
  assign up_hi = lo_co ? hi_inc : hh[W-1:H+LO];

  logic [2*W-1:0] prod_c;
  assign prod_c = {up_hi, up_lo, mid_hi, cs_s[0], ll[H-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_prod  <= '0;
    end else begin
      res_valid <= v_s;
      if (v_s) res_prod <= prod_c;
    end
  end

  logic unused_ok;
  assign unused_ok = hi_co;
endmodule

// File: rtl/vm_mult24_chk.sv
module vm_mult24_chk #(
  parameter int W    = 24,
  parameter int PIPE = 1
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [W-1:0]   op_a,
  input logic [W-1:0]   op_b,
  input logic           res_valid,
  input logic [2*W-1:0] res_prod
);
  localparam int LAT = 1 + ((PIPE != 0) ? 1 : 0);
  localparam int H   = W / 2;

  logic [W-1:0] da [0:LAT-1];
  logic [W-1:0] db [0:LAT-1];
  logic [LAT-1:0] dv;

  always_ff @(posedge clk) begin
    if (rst) begin
      dv <= '0;
      for (int i = 0; i < LAT; i++) begin
        da[i] <= '0;
        db[i] <= '0;
      end
    end else begin
      dv[0] <= in_valid;
      da[0] <= op_a;
      db[0] <= op_b;
      for (int i = 1; i < LAT; i++) begin
        dv[i] <= dv[i-1];
        da[i] <= da[i-1];
        db[i] <= db[i-1];
      end
    end
  end

  logic [2*W-1:0] ref_full;
  logic [2*H-1:0] ref_low;
  assign ref_full = {{W{1'b0}}, da[LAT-1]} * {{W{1'b0}}, db[LAT-1]};
  assign ref_low  = {{H{1'b0}}, da[LAT-1][H-1:0]} * {{H{1'b0}}, db[LAT-1][H-1:0]};

  a_r1_product: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> res_prod == ref_full);

  a_r2_valid_timing: assert property (@(posedge clk) disable iff (rst)
    res_valid == dv[LAT-1]);

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!res_valid && !$past(rst)) |-> $stable(res_prod));

  a_r4_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (!res_valid && res_prod == '0));

  a_r5_low_field: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> res_prod[H-1:0] == ref_low[H-1:0]);
endmodule

bind vm_mult24 vm_mult24_chk #(.W(W), .PIPE(PIPE)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .res_valid(res_valid), .res_prod(res_prod)
);

// File: tb/sim_vm_mult24.sv
module sim_vm_mult24;
  localparam int CLK_PERIOD = 10;
  localparam int W = 24;
  localparam int WD_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic v2, v1;
  logic [2*W-1:0] p2, p1;

  always #(CLK_PERIOD/2) clk = ~clk;

  // u0: pipelined (2 cycles), u1: unpipelined (1 cycle)
  vm_mult24 #(.W(W), .PIPE(1)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .res_valid(v2), .res_prod(p2)
  );
  vm_mult24 #(.W(W), .PIPE(0)) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .res_valid(v1), .res_prod(p1)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic           hv [0:2];
  logic [2*W-1:0] hp [0:2];
  logic [W-1:0]   ha [0:2];
  logic [W-1:0]   hb [0:2];
  logic [2*W-1:0] held1, held2;

  function automatic logic [2*W-1:0] mul_ref(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [2*W-1:0] acc;
    acc = '0;
    for (int i = 0; i < W; i++)
      if (b[i]) acc = acc + ({{W{1'b0}}, a} << i);
    return acc;
  endfunction

  task automatic chk(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 3; i++) begin
      hv[i] = 1'b0; hp[i] = '0; ha[i] = '0; hb[i] = '0;
    end
    held1 = '0;
    held2 = '0;
  endtask

  // One cycle: check outputs against the model, then drive new inputs
  task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    @(negedge clk);
    hv[2] = hv[1]; hp[2] = hp[1]; ha[2] = ha[1]; hb[2] = hb[1];
    hv[1] = hv[0]; hp[1] = hp[0]; ha[1] = ha[0]; hb[1] = hb[0];
    if (hv[1]) held1 = hp[1];
    if (hv[2]) held2 = hp[2];
    chk("R2 valid 1-cycle", {47'b0, v1}, {47'b0, hv[1]});
    chk("R2 valid 2-cycle", {47'b0, v2}, {47'b0, hv[2]});
    if (hv[1]) begin
      chk({tag, " 1-cycle"}, p1, held1);
      chk("R5 low field", {36'b0, p1[11:0]},
          {36'b0, mul_ref({12'b0, ha[1][11:0]}, {12'b0, hb[1][11:0]})[11:0]});
    end else chk("R3 hold 1-cycle", p1, held1);
    if (hv[2]) chk({tag, " 2-cycle"}, p2, held2);
    else       chk("R3 hold 2-cycle", p2, held2);
    in_valid = v; op_a = a; op_b = b;
    hv[0] = v; ha[0] = a; hb[0] = b; hp[0] = mul_ref(a, b);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    clear_model();
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R4 reset state 1-cycle", {v1, p1}, '0);
    chk("R4 reset state 2-cycle", {v2, p2}, '0);
    @(negedge clk);
    rst = 1'b0;

    // Directed corners
    step(1, 24'h000000, 24'h000000, "R7 zero");
    step(1, 24'hFFFFFF, 24'hFFFFFF, "R6 all ones");
    step(1, 24'hFFFFFF, 24'h000001, "R7 max*1");
    step(1, 24'h000001, 24'hFFFFFF, "R7 1*max");
    step(1, 24'h000000, 24'hFFFFFF, "R7 0*max");
    step(1, 24'hFFF000, 24'hFFF000, "R6 high halves");
    step(1, 24'hFFFFFF, 24'hFFF001, "R6 carry ripple");
    step(1, 24'h800000, 24'h800000, "R1 top bit");
    step(0, 24'h123456, 24'h654321, "R3 ignored");
    step(0, 24'hABCDEF, 24'hFEDCBA, "R3 ignored");
    for (int i = 0; i < W; i += 5)
      for (int j = 0; j < W; j += 7)
        step(1, 24'h1 << i, 24'h1 << j, "R1 single bits");
    step(0, 24'h0, 24'h0, "R3 idle");
    step(0, 24'h0, 24'h0, "R3 idle");

    // Random mix, valid about three quarters of cycles
    for (int n = 0; n < 2000; n++)
      step(($urandom % 4) != 0, W'($urandom), W'($urandom), "R1 random");

    // Reset with results in flight
    step(1, 24'hFFFFFF, 24'hFFFFFF, "R1 before reset");
    @(negedge clk);
    in_valid = 1'b1; op_a = 24'h00ABCD; op_b = 24'h000777;
    rst = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R4 reset clears 1-cycle", {v1, p1}, '0);
    chk("R4 reset clears 2-cycle", {v2, p2}, '0);
    @(negedge clk);
    rst = 1'b0;
    clear_model();
    step(0, 24'h0, 24'h0, "R4 flushed");
    step(0, 24'h0, 24'h0, "R4 flushed");
    step(1, 24'hFFFFFF, 24'h000002, "R1 after reset");
    step(1, 24'h000003, 24'h000005, "R1 after reset");
    step(0, 24'h0, 24'h0, "R3 drain");
    step(0, 24'h0, 24'h0, "R3 drain");
    step(0, 24'h0, 24'h0, "R3 drain");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule